// File: doc/BRIEF.md
# Banked Pin Configuration Register File

This block stores the configuration of every pin in a set of general-purpose I/O banks. Software reaches it through a simple word-wide register bus. Each bank owns a window of 32-bit words split into four sections:

- a 4-bit function code per pin,
- an output data bit per pin,
- a 2-bit drive-level field per pin,
- a 2-bit pull field per pin.

Fields narrower than a word are packed side by side. A section whose pins need more than 32 bits continues into the next consecutive word. The bank stride, the offset of each section and every field width are parameters.

On the pin side the block drives, for each pin:

- the selected function code,
- the output value and an output enable,
- the drive level,
- pull-up and pull-down requests.

It also samples the pad levels through a two-stage synchronizer, so that a read of a data word shows the live level on pins that are not driving.

The bus has no back-pressure. A write is taken in the cycle `wr_en` is high. A read is taken in the cycle `rd_en` is high, and its word appears on `rdata` with `rd_valid` one cycle later. Pin-side signals are plain levels.

Top module: `pcfg_regfile`

## Requirements
- R1: After reset every pin has function code 0 (GPIO input), output enable low, no pull request, output value 0 and drive field 1 (20 mA). A drive word therefore reads 0x55555555.
- R2: The field of pin p lies at byte address (p/32)×0x24 + section base + (((p mod 32)×width)/32)×4. Its lowest bit is at ((p mod 32)×width) mod 32. The section bases are: function 0x00 (4-bit fields), data 0x10 (1-bit), drive 0x14 (2-bit), pull 0x1C (2-bit).
- R3: A write changes only the fields located in the addressed word. Other words of the same section, other sections and the other bank keep their values.
- R4: A read of a function, drive or pull word returns the value last written to it, including pull code 3.
- R5: The output enable of a pin is high exactly when its function code is 1 (GPIO output). Code 0 (input) and code 6 (external interrupt) leave it low. The output value of a pin equals its data bit.
- R6: A data-word read returns, for each bit, the stored data bit if that pin's function code is 1. Otherwise it returns the pad level after a two-flop synchronizer.
- R7: A pull code of 1 raises only the pull-up request and a code of 2 raises only the pull-down request. Codes 0 and 3 raise neither. Both requests are never high together.
- R8: The drive output of each pin equals its 2-bit drive field. A value v stands for (v+1)×10 mA, which covers 10 to 40 mA.
- R9: A write to an address outside all mapped words has no effect, and a read of such an address returns 0. This covers addresses at or beyond 2×0x24 and addresses that are not word aligned.
- R10: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high, and `rdata` then carries the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after `rd_en` |
| rd_valid | output | 1 | Read data valid |
| pad_in | input | 64 | Sampled pad levels, one per pin |
| pin_func | output | 256 | Function code per pin, 4 bits each |
| pin_out | output | 64 | Output value per pin |
| pin_oe | output | 64 | Output enable per pin |
| pin_drv | output | 128 | Drive level per pin, 2 bits each |
| pin_pu | output | 64 | Pull-up request per pin |
| pin_pd | output | 64 | Pull-down request per pin |

## Verification
The checker watches four properties on every cycle:

- the one-cycle read handshake,
- that pull-up and pull-down never assert together,
- that unmapped reads return zero,
- that no pin-side configuration moves in a cycle without a write.

The address arithmetic, the isolation of neighbouring fields within a word and across banks, the reset contents and the live-pad readback through the synchronizer depend on specific addresses and values. Only the bench's directed scenarios can show those.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam logic [3:0] FN_IN  = 4'd0;
  localparam logic [3:0] FN_OUT = 4'd1;
  localparam logic [3:0] FN_IRQ = 4'd6;

  localparam logic [1:0] PULL_NONE = 2'd0;
  localparam logic [1:0] PULL_UP   = 2'd1;
  localparam logic [1:0] PULL_DN   = 2'd2;

  // byte address of the word that holds a pin's field
  function automatic int unsigned fld_word_addr(int unsigned pin, int unsigned ppb,
                                                int unsigned fw, int unsigned sec_off,
                                                int unsigned stride);
    int unsigned bitoff;
    bitoff = (pin % ppb) * fw;
    return (pin / ppb) * stride + sec_off + (bitoff / 32) * 4;
  endfunction

  // bit position of a pin's field inside its word
  function automatic int unsigned fld_shift(int unsigned pin, int unsigned ppb, int unsigned fw);
    return ((pin % ppb) * fw) % 32;
  endfunction
endpackage

// File: rtl/pcfg_sync.sv
module pcfg_sync #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pcfg_field_sect.sv
module pcfg_field_sect #(
  parameter int unsigned NPINS   = 64,
  parameter int unsigned PPB     = 32,
  parameter int unsigned FW      = 4,
  parameter int unsigned SEC_OFF = 0,
  parameter int unsigned STRIDE  = 36,
  parameter int unsigned AW      = 8,
  parameter logic [FW-1:0] RST   = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [31:0]         wdata,
  input  logic [NPINS*FW-1:0] rd_src,
  output logic [NPINS*FW-1:0] fld_q,
  output logic [31:0]         rd_word
);
  import pcfg_pkg::*;

  logic [31:0] contrib [NPINS];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int unsigned WADDR = fld_word_addr(p, PPB, FW, SEC_OFF, STRIDE);
    localparam int unsigned SH    = fld_shift(p, PPB, FW);
    logic          hit;
    logic [FW-1:0] fld;

    assign hit = (addr == AW'(WADDR));

    always_ff @(posedge clk) begin
      if (!rst_n)            fld <= RST;
      else if (wr_en && hit) fld <= wdata[SH +: FW];
    end

    assign fld_q[p*FW +: FW] = fld;
    assign contrib[p] = hit ? (32'(rd_src[p*FW +: FW]) << SH) : 32'd0;
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NPINS; p++) rd_word |= contrib[p];
  end
endmodule

// File: rtl/pcfg_regfile.sv
module pcfg_regfile #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned PPB       = 32,
  parameter int unsigned MUX_W     = 4,
  parameter int unsigned DRV_W     = 2,
  parameter int unsigned PULL_W    = 2,
  parameter int unsigned STRIDE    = 36,
  parameter int unsigned MUX_OFF   = 0,
  parameter int unsigned DATA_OFF  = 16,
  parameter int unsigned DRV_OFF   = 20,
  parameter int unsigned PULL_OFF  = 28,
  parameter int unsigned AW        = 8,
  parameter logic [DRV_W-1:0] DRV_RST = DRV_W'(1),
  localparam int unsigned NPINS    = NUM_BANKS * PPB
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic                   rd_valid,
  input  logic [NPINS-1:0]       pad_in,
  output logic [NPINS*MUX_W-1:0] pin_func,
  output logic [NPINS-1:0]       pin_out,
  output logic [NPINS-1:0]       pin_oe,
  output logic [NPINS*DRV_W-1:0] pin_drv,
  output logic [NPINS-1:0]       pin_pu,
  output logic [NPINS-1:0]       pin_pd
);
  import pcfg_pkg::*;

  logic [NPINS*PULL_W-1:0] pull_q;
  logic [NPINS-1:0]        pad_s;
  logic [NPINS-1:0]        data_rd;
  logic [31:0]             w_mux, w_data, w_drv, w_pull;

  pcfg_sync #(.W(NPINS)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_s)
  );

  pcfg_field_sect #(.NPINS(NPINS), .PPB(PPB), .FW(MUX_W), .SEC_OFF(MUX_OFF),
                    .STRIDE(STRIDE), .AW(AW), .RST(FN_IN)) i_mux (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_src(pin_func), .fld_q(pin_func), .rd_word(w_mux)
  );

  pcfg_field_sect #(.NPINS(NPINS), .PPB(PPB), .FW(1), .SEC_OFF(DATA_OFF),
                    .STRIDE(STRIDE), .AW(AW), .RST(1'b0)) i_data (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_src(data_rd), .fld_q(pin_out), .rd_word(w_data)
  );

  pcfg_field_sect #(.NPINS(NPINS), .PPB(PPB), .FW(DRV_W), .SEC_OFF(DRV_OFF),
                    .STRIDE(STRIDE), .AW(AW), .RST(DRV_RST)) i_drv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_src(pin_drv), .fld_q(pin_drv), .rd_word(w_drv)
  );

  pcfg_field_sect #(.NPINS(NPINS), .PPB(PPB), .FW(PULL_W), .SEC_OFF(PULL_OFF),
                    .STRIDE(STRIDE), .AW(AW), .RST(PULL_W'(PULL_NONE))) i_pull (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_src(pull_q), .fld_q(pull_q), .rd_word(w_pull)
  );

  // pin-side decode: output pins read back driven value, all others the pad
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign pin_oe[p]  = (pin_func[p*MUX_W +: MUX_W] == MUX_W'(FN_OUT));
    assign pin_pu[p]  = (pull_q[p*PULL_W +: PULL_W] == PULL_W'(PULL_UP));
    assign pin_pd[p]  = (pull_q[p*PULL_W +: PULL_W] == PULL_W'(PULL_DN));
    assign data_rd[p] = pin_oe[p] ? pin_out[p] : pad_s[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rdata    <= rd_en ? (w_mux | w_data | w_drv | w_pull) : 32'd0;
    end
  end
endmodule

// File: rtl/pcfg_regfile_chk.sv
module pcfg_regfile_chk #(
  parameter int unsigned NPINS  = 64,
  parameter int unsigned FUNC_W = 256,
  parameter int unsigned DRVV_W = 128,
  parameter int unsigned AW     = 8,
  parameter int unsigned MAPPED = 72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic [31:0]       rdata,
  input logic              rd_valid,
  input logic [FUNC_W-1:0] pin_func,
  input logic [NPINS-1:0]  pin_out,
  input logic [DRVV_W-1:0] pin_drv,
  input logic [NPINS-1:0]  pin_pu,
  input logic [NPINS-1:0]  pin_pd
);
  a_r10_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  a_r7_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_pd) == '0);
  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (int'(addr) >= int'(MAPPED))) |=> rdata == 32'd0);
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pin_func) && $stable(pin_out) && $stable(pin_drv)
                && $stable(pin_pu) && $stable(pin_pd)));
endmodule

bind pcfg_regfile pcfg_regfile_chk #(
  .NPINS(NPINS), .FUNC_W(NPINS*MUX_W), .DRVV_W(NPINS*DRV_W), .AW(AW),
  .MAPPED(NUM_BANKS*STRIDE)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .rd_valid(rd_valid), .pin_func(pin_func), .pin_out(pin_out),
  .pin_drv(pin_drv), .pin_pu(pin_pu), .pin_pd(pin_pd)
);

// File: tb/test_pcfg_regfile.sv
module test_pcfg_regfile;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         rd_valid;
  logic [63:0]  pad_in = '0;
  logic [255:0] pin_func;
  logic [63:0]  pin_out, pin_oe, pin_pu, pin_pd;
  logic [127:0] pin_drv;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pcfg_regfile i_pcfg_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .pad_in(pad_in),
    .pin_func(pin_func), .pin_out(pin_out), .pin_oe(pin_oe), .pin_drv(pin_drv),
    .pin_pu(pin_pu), .pin_pd(pin_pd)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R10 rd_valid after read", 64'(rd_valid), 64'd1);
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 func", 64'(pin_func[63:0] | pin_func[255:192]), 64'd0);
    chk("R1 oe", pin_oe, 64'd0);
    chk("R1 pull", pin_pu | pin_pd, 64'd0);
    chk("R1 out", pin_out, 64'd0);
    chk("R1 drv lo", pin_drv[63:0], {32{2'b01}});
    chk("R1 drv hi", pin_drv[127:64], {32{2'b01}});
    bus_read(8'h14, d); chk("R1 drive word b0", 64'(d), 64'h5555_5555);
    bus_read(8'h38, d); chk("R1 drive word b1", 64'(d), 64'h5555_5555);
    @(negedge clk);
    chk("R10 idle valid low", 64'(rd_valid), 64'd0);
  endtask

  task automatic t_mux();
    logic [31:0] d;
    bus_write(8'h04, 32'h0000_0010);   // pin 9 -> output
    chk("R2 pin9 func", 64'(pin_func[9*4 +: 4]), 64'd1);
    chk("R5 oe only pin9", pin_oe, 64'h0000_0000_0000_0200);
    bus_write(8'h30, 32'h6000_0000);   // pin 63 -> interrupt
    chk("R2 pin63 func", 64'(pin_func[63*4 +: 4]), 64'd6);
    chk("R5 irq no oe", pin_oe, 64'h0000_0000_0000_0200);
    bus_read(8'h04, d); chk("R4 mux readback", 64'(d), 64'h10);
    bus_read(8'h30, d); chk("R4 mux readback b1", 64'(d), 64'h6000_0000);
  endtask

  task automatic t_isolation();
    logic [31:0] d;
    bus_read(8'h00, d); chk("R3 b0 word0", 64'(d), 64'd0);
    bus_read(8'h08, d); chk("R3 b0 word2", 64'(d), 64'd0);
    bus_read(8'h28, d); chk("R3 b1 word1", 64'(d), 64'd0);
    chk("R3 pin8 func", 64'(pin_func[8*4 +: 4]), 64'd0);
    chk("R3 pin41 func", 64'(pin_func[41*4 +: 4]), 64'd0);
  endtask

  task automatic t_data();
    logic [31:0] d;
    bus_write(8'h10, 32'h0000_0201);   // bits 9 and 0
    chk("R5 pin_out", pin_out, 64'h0000_0000_0000_0201);
    @(negedge clk);
    pad_in = 64'hA000_0000_0000_0004;
    repeat (3) @(negedge clk);
    // pin9 output -> 1, pin0 input -> pad 0, pin2 pad 1
    bus_read(8'h10, d); chk("R6 data b0", 64'(d), 64'h0000_0204);
    bus_read(8'h34, d); chk("R6 data b1 irq pin", 64'(d), 64'hA000_0000);
  endtask

  task automatic t_pull();
    logic [31:0] d;
    bus_write(8'h1C, 32'h0000_00E4);   // pins0..3 = 0,1,2,3
    chk("R7 pull up", pin_pu, 64'h2);
    chk("R7 pull down", pin_pd, 64'h4);
    bus_read(8'h1C, d); chk("R4 R7 pull readback", 64'(d), 64'hE4);
  endtask

  task automatic t_drive();
    logic [31:0] d;
    bus_write(8'h18, 32'hFFFF_FFFF);   // pins16..31 = 3 (40 mA)
    chk("R8 drv upper", pin_drv[63:32], 64'hFFFF_FFFF);
    chk("R8 drv lower", pin_drv[31:0], 64'h5555_5555);
    bus_write(8'h3C, 32'h0000_0000);   // bank1 pins48..63 = 0 (10 mA)
    chk("R8 drv b1", pin_drv[127:96], 64'd0);
    bus_read(8'h14, d); chk("R3 drv word0 intact", 64'(d), 64'h5555_5555);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_write(8'h48, 32'hFFFF_FFFF);
    bus_write(8'h05, 32'hFFFF_FFFF);
    bus_read(8'h48, d); chk("R9 unmapped read", 64'(d), 64'd0);
    bus_read(8'h05, d); chk("R9 misaligned read", 64'(d), 64'd0);
    bus_read(8'h04, d); chk("R9 neighbour intact", 64'(d), 64'h10);
    chk("R9 oe intact", pin_oe, 64'h0000_0000_0000_0200);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mux();
    t_isolation();
    t_data();
    t_pull();
    t_drive();
    t_unmapped();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule